// File: doc/BRIEF.md
# Watchdog Timer with Byte-Wide Reload Registers

This block is a down-counting watchdog timer. Its 24-bit reload value is held in three byte registers that software writes over a small 8-bit register bus. The bus has an address, a write strobe, a read strobe, write data and read data. The three register addresses are write-only for the reload value and read-only for the live count. A read at one of them returns a byte of the running counter, never the byte that was written.

A restart pulse loads the counter from the reload value. It stands in for the processor refreshing the watchdog. While the tick enable is high, the counter decrements by one each cycle. When the counter hits zero, the block raises a one-cycle timeout pulse and then reloads itself. A load never puts a value below 4 into the counter: a smaller reload value is raised to 4.

Top module: `wdt_reload_timer`

## Requirements
- R1: After reset the stored reload value is 0x000400, the counter holds 0x000400 and the timeout output is low.
- R2: A write at 0xFF1 replaces reload bits [23:16], a write at 0xFF2 replaces bits [15:8] and a write at 0xFF3 replaces bits [7:0]. The other two bytes are left as they were, and the counter does not change until the next load.
- R3: While the read strobe is high, address 0xFF1 reads counter bits [23:16], 0xFF2 reads bits [15:8] and 0xFF3 reads bits [7:0]. In any other case the read data is 0x00.
- R4: When restart is high at a clock edge, the counter takes the reload value at that edge.
- R5: A load of a reload value below 4 puts 4 into the counter. Reload values of 4 or more are loaded unchanged.
- R6: Without restart, a nonzero counter drops by exactly one at each edge where tick_en is high and holds its value when tick_en is low.
- R7: When the counter reaches zero, timeout is high for exactly the one cycle in which the counter reads zero. At the next edge the counter reloads from the stored reload value, clamped as in R5. A counter loaded with the value N therefore times out N enabled ticks after the load.
- R8: When a byte write and a restart fall in the same cycle, the counter loads the reload value with that write already applied.
- R9: Writes to addresses other than 0xFF1, 0xFF2 and 0xFF3 change neither the reload value nor the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable; the counter decrements at each edge where this is high |
| restart | input | 1 | Loads the counter from the reload value |
| reg_addr | input | 12 | Register bus address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data: a byte of the live count, or 0x00 |
| timeout | output | 1 | One-cycle pulse while the counter is zero |

## Verification
The bench sweeps reload values from 0 to 10 and times each one from restart to timeout. A clamp that is missing or off by one shows up as a wrong starting count or a wrong period, and a design that skips the reload after a timeout shows up as a missing second period. It writes a byte and then reads the same address before any restart. A design that returns the stored reload value instead of the count fails there. It also checks writes at neighbouring unmapped addresses, single-byte writes that must leave the other lanes alone, and a write that lands in the same cycle as a restart, where a design that loads the stale value is caught.

// File: rtl/wdt_reload_timer.sv
module wdt_reload_timer #(
  parameter int CNT_W = 24,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'hFF1,
  parameter logic [CNT_W-1:0] RESET_RELOAD = 24'h000400,
  parameter logic [CNT_W-1:0] MIN_RELOAD = 24'h000004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              restart,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              timeout
);
  localparam int NBYTES = CNT_W / 8;

  logic [CNT_W-1:0] reload_q, reload_nx, cnt_q;
  logic [NBYTES-1:0] hit;
  logic to_q;

  function automatic logic [CNT_W-1:0] floor_val(input logic [CNT_W-1:0] v);
    return (v < MIN_RELOAD) ? MIN_RELOAD : v;
  endfunction

  for (genvar i = 0; i < NBYTES; i++) begin : g_dec
    assign hit[i] = (reg_addr == BASE_ADDR + ADDR_W'(i));
  end

  always_comb begin
    reload_nx = reload_q;
    reg_rdata = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (reg_wr && hit[i]) reload_nx[(NBYTES-1-i)*8 +: 8] = reg_wdata;
      if (reg_rd && hit[i]) reg_rdata = cnt_q[(NBYTES-1-i)*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= RESET_RELOAD;
      cnt_q    <= floor_val(RESET_RELOAD);
      to_q     <= 1'b0;
    end else begin
      reload_q <= reload_nx;
      to_q     <= 1'b0;
      if (restart || cnt_q == '0) begin
        cnt_q <= floor_val(reload_nx);
      end else if (tick_en) begin
        cnt_q <= cnt_q - CNT_W'(1);
        to_q  <= (cnt_q == CNT_W'(1));
      end
    end
  end

  assign timeout = to_q;
endmodule

module wdt_reload_timer_chk #(
  parameter int CNT_W = 24,
  parameter logic [CNT_W-1:0] MIN_RELOAD = 24'h000004
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             restart,
  input logic             reg_rd,
  input logic [7:0]       reg_rdata,
  input logic             timeout,
  input logic [CNT_W-1:0] cnt
);
  assert_rdata_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> reg_rdata == 8'h00);
  assert_restart_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> cnt >= MIN_RELOAD);
  assert_decrement_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && tick_en && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1));
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !tick_en && cnt != '0) |=> $stable(cnt));
  assert_timeout_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> cnt == '0);
  assert_timeout_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout && cnt >= MIN_RELOAD);
endmodule

bind wdt_reload_timer wdt_reload_timer_chk #(.CNT_W(CNT_W), .MIN_RELOAD(MIN_RELOAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(restart),
  .reg_rd(reg_rd), .reg_rdata(reg_rdata), .timeout(timeout), .cnt(cnt_q)
);

// File: tb/wdt_reload_timer_tb.sv
`timescale 1ns/100ps
module wdt_reload_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, restart = 1'b0;
  logic [11:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic timeout;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_reload_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(restart),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timeout(timeout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic read_count(output logic [23:0] v);
    reg_rd = 1'b1;
    for (int i = 0; i < 3; i++) begin
      reg_addr = 12'hFF1 + 12'(i);
      #0.2;
      v[(2-i)*8 +: 8] = reg_rdata;
    end
    reg_rd = 1'b0;
    reg_addr = '0;
  endtask

  task automatic write_byte(input logic [11:0] a, input logic [7:0] d, input bit rs);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; restart = rs;
    step();
    reg_wr = 1'b0; restart = 1'b0; reg_addr = '0;
  endtask

  task automatic set_reload(input logic [23:0] v);
    write_byte(12'hFF1, v[23:16], 1'b0);
    write_byte(12'hFF2, v[15:8], 1'b0);
    write_byte(12'hFF3, v[7:0], 1'b0);
  endtask

  task automatic do_restart();
    restart = 1'b1; step(); restart = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] c;
    #5 rst_n = 1'b1;
    #1;
    read_count(c);
    check(c == 24'h000400, "R1 reset count", int'(c), 'h400);
    check(timeout == 1'b0, "R1 reset timeout", int'(timeout), 0);
    step();
    do_restart(); read_count(c);
    check(c == 24'h000400, "R1 default reload", int'(c), 'h400);

    set_reload(24'h123456);
    read_count(c);
    check(c == 24'h000400, "R2 write leaves count", int'(c), 'h400);
    check(reg_rdata == 8'h00, "R3 rdata idle", int'(reg_rdata), 0);
    reg_addr = 12'hFF3; #0.2;
    check(reg_rdata == 8'h00, "R3 no strobe", int'(reg_rdata), 0);
    reg_addr = '0;
    do_restart(); read_count(c);
    check(c == 24'h123456, "R4 restart load", int'(c), 'h123456);

    write_byte(12'hFF2, 8'hA5, 1'b0);
    do_restart(); read_count(c);
    check(c == 24'h12A556, "R2 middle lane only", int'(c), 'h12A556);
    write_byte(12'hFF1, 8'h07, 1'b0);
    do_restart(); read_count(c);
    check(c == 24'h07A556, "R2 upper lane only", int'(c), 'h07A556);

    write_byte(12'hFF0, 8'hEE, 1'b0);
    write_byte(12'hFF4, 8'hEE, 1'b0);
    do_restart(); read_count(c);
    check(c == 24'h07A556, "R9 unmapped writes", int'(c), 'h07A556);
    reg_rd = 1'b1; reg_addr = 12'hFF0; #0.2;
    check(reg_rdata == 8'h00, "R3 unmapped read", int'(reg_rdata), 0);
    reg_rd = 1'b0; reg_addr = '0;

    write_byte(12'hFF3, 8'h99, 1'b1);
    read_count(c);
    check(c == 24'h07A599, "R8 write with restart", int'(c), 'h07A599);

    step(); step(); read_count(c);
    check(c == 24'h07A599, "R6 hold without tick", int'(c), 'h07A599);

    for (int l = 0; l < 11; l++) begin
      int lc;
      int k;
      lc = (l < 4) ? 4 : l;
      set_reload(24'(l));
      do_restart(); read_count(c);
      check(c == 24'(lc), "R5 clamped load", int'(c), lc);
      tick_en = 1'b1;
      k = 0;
      while (!timeout && k < 20) begin
        step(); k++;
        read_count(c);
        check(c == 24'(lc - k), "R6 decrement", int'(c), lc - k);
      end
      check(k == lc, "R7 period", k, lc);
      step();
      check(timeout == 1'b0, "R7 single pulse", int'(timeout), 0);
      read_count(c);
      check(c == 24'(lc), "R7 reload after zero", int'(c), lc);
      tick_en = 1'b0;
      step();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule